// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block sits between a physical-layer core and the parallel interface that connects it to a link-layer controller. It watches the link's power-status input, measures how long that input stays low, and from that decides whether the interface is operational, parked in a low-power reset level, or fully disabled. In the reset level the outbound control and data lines are forced to zero and the link's request line is masked, but the system clock keeps running. In the disabled level the clock enable is dropped as well.

When the status input is seen high again while the interface is parked, the block runs a fixed initialization window with the outputs still clamped, and then returns to operation. While the interface is disabled and no port is active, it raises a low-power request to the rest of the PHY. That request is withdrawn when the link comes back or when a port event needs attention. Each change of interface state is marked by a one-cycle pulse.

The status input is assumed to be already synchronous to `clk`. `clk` is a free-running reference that is never gated by this block.

Top module: `lps_ifc_ctrl`

## Requirements
- R1: The low-time count restarts on every high sample of `lps_in`. A low run of 128 consecutive samples followed by a high sample leaves `ifc_state` operational (2'b00). A run of 129 consecutive low samples moves `ifc_state` to reset (2'b01) on the next rising edge.
- R2: In the reset state (2'b01) and the initialization state (2'b11), `ctl_o` and `d_o` are 0, `lreq_o` is 0, `out_hold` and `req_ignore` are 1, and `clk_en` stays 1.
- R3: A run of 1281 consecutive low samples moves `ifc_state` from reset to disabled (2'b10) on the next rising edge. `clk_en` is 0 only in the disabled state.
- R4: While `rst_n` is low, `ifc_state` is disabled, `clk_en` is 0, and `lp_req` and `state_chg` are 0. After `rst_n` is released, the state stays disabled for as long as `lps_in` is sampled low.
- R5: A high sample of `lps_in` in the reset or disabled state moves `ifc_state` to initialization (2'b11) at that edge. The state then stays there for exactly 16 cycles and becomes operational on the 16th edge after entry. It never goes from reset or disabled straight to operational.
- R6: In the operational state, `ctl_o`, `d_o` and `lreq_o` follow `ctl_i`, `d_i` and `lreq_i`, and `out_hold`, `req_ignore` are 0.
- R7: `lp_req` rises one edge after the interface is disabled when `lps_in` is low, every `port_active` bit is 0 and no port event is pending. It falls on the edge that samples `lps_in` high.
- R8: A `port_event` pulse clears `lp_req` on the edge that samples it. `lp_req` then stays 0 until the interface leaves the disabled state. Any set `port_active` bit also holds `lp_req` at 0.
- R9: `state_chg` is 1 for exactly the first cycle of each new `ifc_state` value and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| lps_in | input | 1 | Link power status, synchronous to clk |
| port_active | input | NUM_PORTS | One bit per cable port, 1 = active |
| port_event | input | 1 | Single-cycle port event needing attention |
| ctl_i | input | CTL_W | Control bits headed to the link |
| d_i | input | DATA_W | Data bits headed to the link |
| lreq_i | input | 1 | Request line from the link |
| ctl_o | output | CTL_W | Gated control bits |
| d_o | output | DATA_W | Gated data bits |
| lreq_o | output | 1 | Gated request to the PHY core |
| ifc_state | output | 2 | 00 operational, 01 reset, 10 disabled, 11 initialization |
| out_hold | output | 1 | Outputs clamped to zero |
| req_ignore | output | 1 | Link request masked |
| clk_en | output | 1 | System clock output enable |
| lp_req | output | 1 | Low-power mode request |
| state_chg | output | 1 | One-cycle pulse on each state change |

## Verification
The bench targets the off-by-one edges of both thresholds. A run of 128 low samples must not leave operation, while a run of 129 must, and the step to disabled must come exactly at the 1281-sample mark. A counter compared with `>=` instead of `>`, or one that fails to restart on a high sample, shows up as an early or spurious state change. The initialization window is timed to the cycle, so a counter that runs 15 or 17 cycles reports the wrong state at its last edge. The low-power request is checked against a single-cycle port event that must be remembered: a design that only masks the request during the event cycle lets it rise again 20 cycles later. The bench also drives a hardware reset in the middle of operation and then releases it with the status input low, where a design that initializes without a high sample would leave the disabled state.

// File: rtl/lps_ifc_pkg.sv
// Package: shared interface state encoding for the link power status controller.
// The code values are visible on the top-level ifc_state port.
package lps_ifc_pkg;

    typedef enum logic [1:0] {
        IFC_OPER = 2'b00,
        IFC_RST  = 2'b01,
        IFC_DIS  = 2'b10,
        IFC_INIT = 2'b11
    } ifc_state_e;

endpackage

// File: rtl/lps_low_timer.sv
// Module: lps_low_timer
// Counts consecutive low samples of the link power status input.
// Flags "inactive" once the count exceeds RESET_LIM and "long inactive"
// once it exceeds DISABLE_LIM. The count restarts on any high sample and
// saturates one above DISABLE_LIM.
// Assumes lps_in is already synchronous to clk and that clk is never gated.
module lps_low_timer #(
    parameter int RESET_LIM   = 128,
    parameter int DISABLE_LIM = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    output logic low_rst,
    output logic low_dis
);

    localparam int              CNT_W  = $clog2(DISABLE_LIM + 2);
    localparam logic [CNT_W-1:0] RST_TH = CNT_W'(RESET_LIM);
    localparam logic [CNT_W-1:0] DIS_TH = CNT_W'(DISABLE_LIM);
    localparam logic [CNT_W-1:0] SAT    = CNT_W'(DISABLE_LIM + 1);

    logic [CNT_W-1:0] low_cnt_q;

    // Purpose: count low samples, restart on high, hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (lps_in) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != SAT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Purpose: compare the count against both thresholds.
    always_comb begin
        low_rst = (low_cnt_q > RST_TH);
        low_dis = (low_cnt_q > DIS_TH);
    end

endmodule

// File: rtl/lps_ifc_fsm.sv
// Module: lps_ifc_fsm
// Four-state interface power manager: operational, low-power reset,
// low-power disabled and initialization. Hardware reset forces the
// disabled state. A high status sample in reset or disabled starts a
// fixed INIT_CYCLES initialization window, after which the interface is
// operational. Emits a one-cycle pulse in the first cycle of each new state.
// Assumes low_rst and low_dis come from a counter that restarts on high samples.
module lps_ifc_fsm
    import lps_ifc_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_in,
    input  logic       low_rst,
    input  logic       low_dis,
    output ifc_state_e state,
    output logic       state_chg
);

    localparam int               INIT_W    = $clog2(INIT_CYCLES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

    ifc_state_e        state_q, state_d;
    logic [INIT_W-1:0] init_q;
    logic              chg_q;

    // Purpose: choose the next interface state from the status observations.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IFC_OPER: if (low_rst) state_d = IFC_RST;
            IFC_RST: begin
                if (lps_in)       state_d = IFC_INIT;
                else if (low_dis) state_d = IFC_DIS;
            end
            IFC_DIS:  if (lps_in) state_d = IFC_INIT;
            IFC_INIT: begin
                if (low_rst)                  state_d = IFC_RST;
                else if (init_q == INIT_LAST) state_d = IFC_OPER;
            end
            default: state_d = IFC_DIS;
        endcase
    end

    // Purpose: hold the state register; hardware reset parks it disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IFC_DIS;
        else        state_q <= state_d;
    end

    // Purpose: time the initialization window; idle at zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != IFC_INIT) init_q <= '0;
        else                               init_q <= init_q + 1'b1;
    end

    // Purpose: register a pulse aligned with the first cycle of a new state.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= (state_d != state_q);
    end

    assign state     = state_q;
    assign state_chg = chg_q;

endmodule

// File: rtl/lps_ifc_gate.sv
// Module: lps_ifc_gate
// Applies the interface state to the link-facing signals. Outbound control
// and data are clamped to zero and the link request is masked whenever the
// interface is not operational. The clock enable drops only when disabled.
// Purely combinational; assumes state is a registered value.
module lps_ifc_gate
    import lps_ifc_pkg::*;
#(
    parameter int CTL_W  = 2,
    parameter int DATA_W = 8
) (
    input  ifc_state_e        state,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [DATA_W-1:0] d_i,
    input  logic              lreq_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] d_o,
    output logic              lreq_o,
    output logic              out_hold,
    output logic              req_ignore,
    output logic              clk_en
);

    logic hold;

    // Purpose: derive the clamp, mask and clock-enable controls.
    always_comb begin
        hold       = (state != IFC_OPER);
        out_hold   = hold;
        req_ignore = hold;
        clk_en     = (state != IFC_DIS);
    end

    // Purpose: force the link-facing data path to zero while held.
    always_comb begin
        ctl_o  = hold ? '0 : ctl_i;
        d_o    = hold ? '0 : d_i;
        lreq_o = hold ? 1'b0 : lreq_i;
    end

endmodule

// File: rtl/lps_sleep_req.sv
// Module: lps_sleep_req
// Raises a registered low-power request while the interface is disabled,
// the status input is low, and no port is active. A port event is latched
// and blocks the request until the interface leaves the disabled state.
// Assumes port_event is a single-cycle pulse synchronous to clk.
module lps_sleep_req
    import lps_ifc_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ifc_state_e           state,
    input  logic                 lps_in,
    input  logic [NUM_PORTS-1:0] port_active,
    input  logic                 port_event,
    output logic                 lp_req
);

    logic wake_q;
    logic req_q;
    logic all_idle;

    // Purpose: detect that every port is inactive.
    always_comb all_idle = ~|port_active;

    // Purpose: remember a port event for the rest of the disabled stay.
    always_ff @(posedge clk) begin
        if (!rst_n || state != IFC_DIS) wake_q <= 1'b0;
        else if (port_event)            wake_q <= 1'b1;
    end

    // Purpose: register the low-power request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= (state == IFC_DIS) && all_idle && !lps_in
                             && !port_event && !wake_q;
    end

    assign lp_req = req_q;

endmodule

// File: rtl/lps_ifc_ctrl.sv
// Module: lps_ifc_ctrl (top)
// Link power status interface controller. Measures the low time of the
// link power status input, runs the four-state interface manager, gates the
// link-facing signals and produces the low-power request.
// Assumes lps_in is synchronous to the free-running clk.
module lps_ifc_ctrl #(
    parameter int NUM_PORTS   = 6,
    parameter int CTL_W       = 2,
    parameter int DATA_W      = 8,
    parameter int RESET_LIM   = 128,
    parameter int DISABLE_LIM = 1280,
    parameter int INIT_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lps_in,
    input  logic [NUM_PORTS-1:0] port_active,
    input  logic                 port_event,
    input  logic [CTL_W-1:0]     ctl_i,
    input  logic [DATA_W-1:0]    d_i,
    input  logic                 lreq_i,
    output logic [CTL_W-1:0]     ctl_o,
    output logic [DATA_W-1:0]    d_o,
    output logic                 lreq_o,
    output logic [1:0]           ifc_state,
    output logic                 out_hold,
    output logic                 req_ignore,
    output logic                 clk_en,
    output logic                 lp_req,
    output logic                 state_chg
);

    import lps_ifc_pkg::*;

    logic       low_rst;
    logic       low_dis;
    ifc_state_e state;

    lps_low_timer #(
        .RESET_LIM  (RESET_LIM),
        .DISABLE_LIM(DISABLE_LIM)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .lps_in (lps_in),
        .low_rst(low_rst),
        .low_dis(low_dis)
    );

    lps_ifc_fsm #(
        .INIT_CYCLES(INIT_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lps_in   (lps_in),
        .low_rst  (low_rst),
        .low_dis  (low_dis),
        .state    (state),
        .state_chg(state_chg)
    );

    lps_ifc_gate #(
        .CTL_W (CTL_W),
        .DATA_W(DATA_W)
    ) u_gate (
        .state     (state),
        .ctl_i     (ctl_i),
        .d_i       (d_i),
        .lreq_i    (lreq_i),
        .ctl_o     (ctl_o),
        .d_o       (d_o),
        .lreq_o    (lreq_o),
        .out_hold  (out_hold),
        .req_ignore(req_ignore),
        .clk_en    (clk_en)
    );

    lps_sleep_req #(
        .NUM_PORTS(NUM_PORTS)
    ) u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .lps_in     (lps_in),
        .port_active(port_active),
        .port_event (port_event),
        .lp_req     (lp_req)
    );

    assign ifc_state = state;

endmodule

// File: rtl/lps_ifc_ctrl_chk.sv
// Module: lps_ifc_ctrl_chk
// Property checker for lps_ifc_ctrl, attached through the bind below.
// Observes ports only.
module lps_ifc_ctrl_chk #(
    parameter int NUM_PORTS = 6,
    parameter int CTL_W     = 2,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] port_active,
    input logic [CTL_W-1:0]     ctl_o,
    input logic [DATA_W-1:0]    d_o,
    input logic                 lreq_o,
    input logic [1:0]           ifc_state,
    input logic                 clk_en,
    input logic                 lp_req,
    input logic                 state_chg
);

    localparam logic [1:0] S_OPER = 2'b00;
    localparam logic [1:0] S_RST  = 2'b01;
    localparam logic [1:0] S_DIS  = 2'b10;

    p_oper_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ifc_state == S_OPER) |=> (ifc_state == S_OPER || ifc_state == S_RST));

    p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ifc_state != S_OPER) |-> (ctl_o == '0 && d_o == '0 && !lreq_o));

    p_clk_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |-> (ifc_state == S_DIS));

    p_hw_reset_r4: assert property (@(posedge clk)
        (!rst_n) |=> (ifc_state == S_DIS && !lp_req && !state_chg));

    p_no_skip_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ifc_state == S_RST || ifc_state == S_DIS) |=> (ifc_state != S_OPER));

    p_lpreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> (ifc_state == S_DIS && $past(port_active) == '0));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_chg |-> (ifc_state != $past(ifc_state)));

endmodule

bind lps_ifc_ctrl lps_ifc_ctrl_chk #(
    .NUM_PORTS(NUM_PORTS),
    .CTL_W    (CTL_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_active(port_active),
    .ctl_o      (ctl_o),
    .d_o        (d_o),
    .lreq_o     (lreq_o),
    .ifc_state  (ifc_state),
    .clk_en     (clk_en),
    .lp_req     (lp_req),
    .state_chg  (state_chg)
);

// File: tb/sim_lps_ifc_ctrl.sv
// Directed bench for lps_ifc_ctrl. Inputs change and outputs are sampled
// on falling edges; each scenario task checks its own results.
module sim_lps_ifc_ctrl;

    localparam int NP = 6;
    localparam logic [1:0] OPER = 2'b00, RSTS = 2'b01, DIS = 2'b10, INIT = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lps_in;
    logic [NP-1:0] port_active;
    logic          port_event;
    logic [1:0]    ctl_i;
    logic [7:0]    d_i;
    logic          lreq_i;
    logic [1:0]    ctl_o;
    logic [7:0]    d_o;
    logic          lreq_o;
    logic [1:0]    ifc_state;
    logic          out_hold, req_ignore, clk_en, lp_req, state_chg;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lps_ifc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .port_active(port_active),
        .port_event(port_event), .ctl_i(ctl_i), .d_i(d_i), .lreq_i(lreq_i),
        .ctl_o(ctl_o), .d_o(d_o), .lreq_o(lreq_o), .ifc_state(ifc_state),
        .out_hold(out_hold), .req_ignore(req_ignore), .clk_en(clk_en),
        .lp_req(lp_req), .state_chg(state_chg)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    task automatic t_hw_reset;
        rst_n = 1'b0; lps_in = 1'b1; port_active = '0; port_event = 1'b0;
        ctl_i = 2'b10; d_i = 8'hA5; lreq_i = 1'b1;
        step(3);
        chk("R4", "state in reset", ifc_state, DIS);
        chk("R4", "clk_en in reset", clk_en, 0);
        chk("R4", "lp_req in reset", lp_req, 0);
        chk("R4", "state_chg in reset", state_chg, 0);
    endtask

    task automatic t_init_after_reset;
        rst_n = 1'b1;
        step(1);
        chk("R5", "enter init", ifc_state, INIT);
        chk("R9", "pulse on init entry", state_chg, 1);
        chk("R2", "ctl/d clamped in init", {ctl_o, d_o, lreq_o}, 0);
        chk("R2", "clk_en in init", clk_en, 1);
        step(1);
        chk("R9", "pulse is one cycle", state_chg, 0);
        step(14);
        chk("R5", "still init at 15th edge", ifc_state, INIT);
        step(1);
        chk("R5", "operational at 16th edge", ifc_state, OPER);
        chk("R9", "pulse on oper entry", state_chg, 1);
    endtask

    task automatic t_passthrough;
        ctl_i = 2'b01; d_i = 8'h3C; lreq_i = 1'b1;
        step(1);
        chk("R6", "ctl pass", ctl_o, 2'b01);
        chk("R6", "data pass", d_o, 8'h3C);
        chk("R6", "request pass", lreq_o, 1);
        chk("R6", "no hold", {out_hold, req_ignore}, 0);
    endtask

    task automatic t_short_lows;
        for (int k = 0; k < 3; k++) begin
            lps_in = 1'b0; step(128);
            lps_in = 1'b1; step(1);
        end
        step(2);
        chk("R1", "128-sample lows stay operational", ifc_state, OPER);
    endtask

    task automatic t_reset_entry;
        lps_in = 1'b0;
        step(129);
        chk("R1", "operational after 129 lows", ifc_state, OPER);
        step(1);
        chk("R1", "reset after 129 lows", ifc_state, RSTS);
        chk("R9", "pulse on reset entry", state_chg, 1);
        ctl_i = 2'b11; d_i = 8'hFF; lreq_i = 1'b1;
        step(1);
        chk("R2", "outputs clamped in reset", {ctl_o, d_o, lreq_o}, 0);
        chk("R2", "hold flags in reset", {out_hold, req_ignore}, 2'b11);
        chk("R2", "clock kept in reset", clk_en, 1);
    endtask

    task automatic t_disable_entry;
        // 131 low samples taken so far
        step(1281 - 131);
        chk("R3", "still reset at 1281 lows", ifc_state, RSTS);
        chk("R3", "clock on before disable", clk_en, 1);
        step(1);
        chk("R3", "disabled after 1281 lows", ifc_state, DIS);
        chk("R3", "clock off when disabled", clk_en, 0);
        chk("R7", "no request yet", lp_req, 0);
        step(1);
        chk("R7", "request raised", lp_req, 1);
    endtask

    task automatic t_port_block;
        port_active = 6'b000100;
        step(1);
        chk("R8", "active port blocks request", lp_req, 0);
        port_active = '0;
        step(1);
        chk("R8", "request back when idle", lp_req, 1);
        port_event = 1'b1;
        step(1);
        port_event = 1'b0;
        chk("R8", "event clears request", lp_req, 0);
        step(20);
        chk("R8", "event remembered", lp_req, 0);
        chk("R4", "stays disabled while low", ifc_state, DIS);
        lps_in = 1'b1;
        step(1);
        chk("R5", "disabled to init", ifc_state, INIT);
        step(16);
        chk("R5", "operational after init", ifc_state, OPER);
    endtask

    task automatic t_lps_wake;
        lps_in = 1'b0;
        step(1282);
        chk("R3", "disabled again", ifc_state, DIS);
        step(1);
        chk("R7", "request raised again", lp_req, 1);
        lps_in = 1'b1;
        step(1);
        chk("R7", "request drops on high sample", lp_req, 0);
        chk("R5", "init on high sample", ifc_state, INIT);
        step(16);
        chk("R5", "operational again", ifc_state, OPER);
    endtask

    task automatic t_reset_to_init;
        lps_in = 1'b0;
        step(130);
        chk("R1", "reset level", ifc_state, RSTS);
        lps_in = 1'b1;
        step(1);
        chk("R5", "reset to init", ifc_state, INIT);
        chk("R9", "pulse reset to init", state_chg, 1);
        step(16);
        chk("R5", "operational from reset path", ifc_state, OPER);
    endtask

    task automatic t_midrun_reset;
        rst_n = 1'b0;
        step(1);
        chk("R4", "hw reset forces disabled", ifc_state, DIS);
        chk("R4", "hw reset drops clock", clk_en, 0);
        lps_in = 1'b0; rst_n = 1'b1;
        step(5);
        chk("R4", "no init without high sample", ifc_state, DIS);
    endtask

    initial begin
        t_hw_reset();
        t_init_after_reset();
        t_passthrough();
        t_short_lows();
        t_reset_entry();
        t_disable_entry();
        t_port_block();
        t_lps_wake();
        t_reset_to_init();
        t_midrun_reset();
        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete (R1..R9 unfinished)");
            report();
            $finish;
        end
    end

endmodule